// File: doc/BRIEF.md
# Dual-Width Local Bus Register Port

This block is the slave side of a synchronous local bus that a microprocessor uses to reach a bank of 32-bit operation registers. Chip select, read enable and write enable are separate active-low inputs. A word address picks the register, and active-low byte enables pick the lanes. A width-mode input sets the bus to the full 32 bits or to 16 bits. The data bus is a tri-state bus, brought out as an input word, an output word and an output enable, so the pad ring builds the tri-state buffer.

In 16-bit mode the top byte-enable pin is no longer a byte enable. It becomes address bit 1 and selects the lower or upper half of the addressed register. The third byte-enable pin has no effect in this mode. Each 32-bit register therefore takes two accesses, and the two remaining byte enables are steered onto whichever half is selected. Two register slots are reserved for the pass-through data and address registers. These always use the full 32-bit path, whatever the width mode says.

All inputs are sampled on the rising clock edge. A write takes effect at the edge that samples it. Read data is registered at the edge that samples the read and is driven during the following cycle.

Top module: `lbus_regport`

## Requirements
- R1: A synchronous active-low reset clears every register to zero and leaves the data output enable low with a zero output word.
- R2: While chip select is high, no register changes and no read is driven, even if the read and write enables are low.
- R3: In 32-bit mode (width input low), a write updates byte k of the addressed register from data bits 8k+7:8k only when byte enable k is low (enable 0 maps to bits 7:0, up to enable 3 for bits 31:24). Every other byte keeps its value.
- R4: A read sampled at an edge raises the output enable during the next cycle, with the addressed register's full 32-bit value on the output word.
- R5: In any cycle that does not follow a sampled read, the output enable is low and the output word is zero.
- R6: In 16-bit mode (width input high), byte-enable pin 3 acts as address bit 1. A value of 0 selects bytes 1:0 and a value of 1 selects bytes 3:2. Byte enables 0 and 1 (active low) write input bits 7:0 and 15:8 into the lower and upper byte of the selected half. Input bits 31:16 are ignored.
- R7: In 16-bit mode, byte-enable pin 2 has no effect on any write.
- R8: In 16-bit mode, a read drives the selected half-word on output bits 15:0 and zero on bits 31:16.
- R9: The pass-through registers at word addresses 28 (data) and 29 (address) always behave as in 32-bit mode, even when the width input is high.
- R10: A read in the cycle right after a write returns the new value. A read and a write sampled at the same edge return the value the register held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local bus clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low chip select, qualifies every other control input |
| rd_n | input | 1 | Active-low read enable |
| wr_n | input | 1 | Active-low write enable |
| word_addr | input | 5 | Register word address (byte address bits 6:2) |
| be_n | input | 4 | Active-low byte enables; in 16-bit mode pin 3 is address bit 1 and pin 2 is ignored |
| bus16 | input | 1 | Width mode: 0 = 32-bit bus, 1 = 16-bit bus |
| dq_i | input | 32 | Data from the bus pads |
| dq_o | output | 32 | Data to the bus pads |
| dq_oe | output | 1 | Drive enable for the bus pads |

## Verification
A write lands at the rising edge that samples it, so its effect can only be seen through a read. Read data and the output enable appear one register stage after the sampling edge. The bench changes inputs on falling edges and samples the outputs at the next falling edge after the sampling rising edge. One falling edge later it checks that the enable has dropped and the output word is zero. The sweeps cover every register address and all 16 byte-enable patterns in 32-bit mode. In 16-bit mode they cover both half selects, every value of the two active enables, and both levels of the ignored pin. For a same-edge read and write, the bench expects the old value in the cycle after the edge and the new value on a later read.

// File: rtl/lbus_pkg.sv
// Package lbus_pkg
// Shared widths and types for the dual-width register port.
// Assumes registers are 32 bits wide, made of four 8-bit lanes.
package lbus_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int HALF_W = WORD_W / 2;
    localparam int HALF_LANES = LANES / 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [LANES-1:0]  lane_t;

    typedef enum logic {
        BUS_FULL = 1'b0,
        BUS_HALF = 1'b1
    } bus_width_e;

    // Expand a lane mask into a bit mask.
    function automatic word_t lanes_to_bits(lane_t lanes);
        word_t m;
        for (int k = 0; k < LANES; k++) begin
            m[k*BYTE_W +: BYTE_W] = {BYTE_W{lanes[k]}};
        end
        return m;
    endfunction
endpackage

// File: rtl/lbus_decode.sv
// Module lbus_decode
// Decodes one local bus access. It qualifies the strobes with chip select,
// decides whether the access is narrow (16-bit mode on a register that is not
// a pass-through register), turns the byte-enable pins into a lane write mask,
// and copies the low half of the input onto both halves so either half can be
// written.
// Assumes: all inputs are stable around the sampling edge; purely combinational.
module lbus_decode
    import lbus_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int NUM_REGS    = 32,
    parameter int PT_DATA_IDX = 28,
    parameter int PT_ADDR_IDX = 29
) (
    input  logic              sel_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [LANES-1:0]  be_n,
    input  logic              bus16,
    input  word_t             dq_i,
    output logic              wr_en,
    output logic              rd_en,
    output logic [ADDR_W-1:0] idx,
    output lane_t             lane_we,
    output word_t             wdata,
    output logic              narrow,
    output logic              half_hi
);
    localparam int HALF_SEL_PIN = LANES - 1;

    logic       in_range;
    logic       is_pt;
    bus_width_e width;
    lane_t      full_mask;
    lane_t      half_mask;
    half_t      low_half;

    // Find out whether the address is a real register and whether it is a pass-through register.
    always_comb begin
        in_range = (32'(word_addr) < 32'(NUM_REGS));
        is_pt    = (32'(word_addr) == 32'(PT_DATA_IDX)) ||
                   (32'(word_addr) == 32'(PT_ADDR_IDX));
    end

    // Choose the width that applies; pass-through registers always use the full width.
    always_comb begin
        width   = (bus16 && !is_pt) ? BUS_HALF : BUS_FULL;
        narrow  = (width == BUS_HALF);
        half_hi = narrow && be_n[HALF_SEL_PIN];
    end

    // Build the lane masks: the full mask comes straight from the pins, the half mask steers two enables to one half.
    always_comb begin
        full_mask = ~be_n;
        half_mask = '0;
        for (int k = 0; k < HALF_LANES; k++) begin
            if (half_hi) begin
                half_mask[HALF_LANES + k] = ~be_n[k];
            end else begin
                half_mask[k] = ~be_n[k];
            end
        end
        lane_we = narrow ? half_mask : full_mask;
    end

    // Put the write data on the lanes; in narrow mode the low half is copied to both halves.
    always_comb begin
        low_half = dq_i[HALF_W-1:0];
        wdata    = narrow ? {low_half, low_half} : dq_i;
    end

    // Qualify the strobes with chip select; writes outside the bank are dropped.
    always_comb begin
        wr_en = !sel_n && !wr_n && in_range;
        rd_en = !sel_n && !rd_n;
        idx   = word_addr;
    end
endmodule

// File: rtl/lbus_regfile.sv
// Module lbus_regfile
// Bank of 32-bit registers with one write port that has lane enables and one
// combinational read port. Addresses outside the bank read as zero.
// Assumes: the write index is in range whenever wr_en is high.
module lbus_regfile
    import lbus_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int NUM_REGS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] widx,
    input  lane_t             lane_we,
    input  word_t             wdata,
    input  logic [ADDR_W-1:0] ridx,
    output word_t             rword
);
    logic [NUM_REGS-1:0][WORD_W-1:0] mem;

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            for (genvar k = 0; k < LANES; k++) begin : g_lane
                // Store one byte lane of one register; reset clears it.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        mem[r][k*BYTE_W +: BYTE_W] <= '0;
                    end else if (wr_en && (32'(widx) == r) && lane_we[k]) begin
                        mem[r][k*BYTE_W +: BYTE_W] <= wdata[k*BYTE_W +: BYTE_W];
                    end
                end
            end
        end
    endgenerate

    // Read port: the addressed register, or zero when the address is outside the bank.
    always_comb begin
        rword = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (32'(ridx) == r) begin
                rword = mem[r];
            end
        end
    end

    // With no write strobe, the whole bank keeps its value.
    assert_bank_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem))
        else $error("bank changed without a write strobe");

    // Lanes that were not enabled keep their value across a write.
    assert_masked_lanes_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem[$past(widx)] & ~lanes_to_bits($past(lane_we))) ==
                   ($past(mem[widx]) & ~lanes_to_bits($past(lane_we)))))
        else $error("unselected lane was overwritten");

    // Lanes that were enabled take the written data.
    assert_enabled_lanes_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem[$past(widx)] & lanes_to_bits($past(lane_we))) ==
                   ($past(wdata) & lanes_to_bits($past(lane_we)))))
        else $error("enabled lane missed the write data");
endmodule

// File: rtl/lbus_rdmux.sv
// Module lbus_rdmux
// Read return path. At the sampling edge it registers either the full
// register word or the selected half-word (zero-extended), and raises the
// output enable for exactly the next cycle.
// Assumes: rword is the value of the addressed register before any write at the same edge.
module lbus_rdmux
    import lbus_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_en,
    input  logic  narrow,
    input  logic  half_hi,
    input  word_t rword,
    output word_t dq_o,
    output logic  dq_oe
);
    word_t steered;
    logic  narrow_q;

    // Choose what the bus sees: the full word, or the selected half zero-extended.
    always_comb begin
        if (!narrow) begin
            steered = rword;
        end else if (half_hi) begin
            steered = {{HALF_W{1'b0}}, rword[WORD_W-1:HALF_W]};
        end else begin
            steered = {{HALF_W{1'b0}}, rword[HALF_W-1:0]};
        end
    end

    // Register the read data and the drive enable; between reads the output is zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_o     <= '0;
            dq_oe    <= 1'b0;
            narrow_q <= 1'b0;
        end else begin
            dq_o     <= rd_en ? steered : '0;
            dq_oe    <= rd_en;
            narrow_q <= rd_en && narrow;
        end
    end

    // A narrow read never drives the upper half of the bus.
    assert_narrow_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && narrow_q) |-> (dq_o[WORD_W-1:HALF_W] == '0))
        else $error("narrow read drove the upper half");

    // With the drive enable low, the output word is zero.
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_o == '0))
        else $error("output word not zero while idle");
endmodule

// File: rtl/lbus_regport.sv
// Module lbus_regport
// Dual-width local bus slave port for a bank of 32-bit operation registers.
// Chain: decode -> register bank -> registered read return.
// Assumes: the tri-state pad is outside the block and driven by dq_o and dq_oe;
// the pass-through register slots are named by parameters.
module lbus_regport
    import lbus_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int NUM_REGS    = 32,
    parameter int PT_DATA_IDX = 28,
    parameter int PT_ADDR_IDX = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [3:0]        be_n,
    input  logic              bus16,
    input  logic [31:0]       dq_i,
    output logic [31:0]       dq_o,
    output logic              dq_oe
);
    logic              wr_en;
    logic              rd_en;
    logic [ADDR_W-1:0] idx;
    lane_t             lane_we;
    word_t             wdata;
    logic              narrow;
    logic              half_hi;
    word_t             rword;

    lbus_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_REGS   (NUM_REGS),
        .PT_DATA_IDX(PT_DATA_IDX),
        .PT_ADDR_IDX(PT_ADDR_IDX)
    ) u_decode (
        .sel_n    (sel_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .word_addr(word_addr),
        .be_n     (be_n),
        .bus16    (bus16),
        .dq_i     (dq_i),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .idx      (idx),
        .lane_we  (lane_we),
        .wdata    (wdata),
        .narrow   (narrow),
        .half_hi  (half_hi)
    );

    lbus_regfile #(
        .ADDR_W  (ADDR_W),
        .NUM_REGS(NUM_REGS)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .widx   (idx),
        .lane_we(lane_we),
        .wdata  (wdata),
        .ridx   (idx),
        .rword  (rword)
    );

    lbus_rdmux u_rdret (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .narrow (narrow),
        .half_hi(half_hi),
        .rword  (rword),
        .dq_o   (dq_o),
        .dq_oe  (dq_oe)
    );

    // With chip select high, nothing is driven in the next cycle.
    assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !dq_oe)
        else $error("bus driven after an unselected cycle");

    // The drive enable only follows a selected read at the previous edge.
    assert_oe_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(!sel_n && !rd_n))
        else $error("bus driven without a read");

    // A narrow write never touches both halves at once.
    assert_half_steer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && narrow) |-> !((|lane_we[3:2]) && (|lane_we[1:0])))
        else $error("narrow write spans both halves");
endmodule

// File: tb/lbus_regport_tb.sv
// Bench for lbus_regport: sweeps addresses, byte-enable patterns and both
// width modes, and checks against a model built from the requirements.
module lbus_regport_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_n, rd_n, wr_n, bus16;
    logic [4:0]  word_addr;
    logic [3:0]  be_n;
    logic [31:0] dq_i, dq_o;
    logic        dq_oe;

    logic [31:0] model [32];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lbus_regport dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
        .word_addr(word_addr), .be_n(be_n), .bus16(bus16), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    function automatic bit is_pt(int a);
        return (a == 28) || (a == 29);
    endfunction

    function automatic logic [31:0] pat(int a, int k);
        return (32'h9E3779B9 * (a + 1)) ^ (32'h01010101 * k) ^ 32'h5A5A0000;
    endfunction

    // Model a write from R3, R6, R7 and R9.
    function automatic void model_write(int a, logic [3:0] be, logic w16, logic [31:0] d);
        if (w16 && !is_pt(a)) begin
            for (int j = 0; j < 2; j++) begin
                if (!be[j]) model[a][(be[3]*2 + j)*8 +: 8] = d[j*8 +: 8];
            end
        end else begin
            for (int j = 0; j < 4; j++) begin
                if (!be[j]) model[a][j*8 +: 8] = d[j*8 +: 8];
            end
        end
    endfunction

    function automatic logic [31:0] exp_read(int a, logic hi, logic w16);
        if (w16 && !is_pt(a)) return hi ? {16'h0, model[a][31:16]} : {16'h0, model[a][15:0]};
        return model[a];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; be_n = 4'hF;
    endtask

    task automatic wr_acc(int a, logic [3:0] be, logic w16, logic [31:0] d);
        @(negedge clk);
        sel_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1;
        word_addr = 5'(a); be_n = be; bus16 = w16; dq_i = d;
        @(negedge clk);
        idle();
        model_write(a, be, w16, d);
    endtask

    task automatic rd_acc(int a, logic hi, logic w16, string req);
        @(negedge clk);
        sel_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
        word_addr = 5'(a); be_n = {hi, 3'b111}; bus16 = w16; dq_i = 32'hDEAD_BEEF;
        @(negedge clk);
        idle();
        check({req, " oe"}, {31'h0, dq_oe}, 32'h1);
        check(req, dq_o, exp_read(a, hi, w16));
        @(negedge clk);
        check("R5 oe", {31'h0, dq_oe}, 32'h0);
        check("R5 data", dq_o, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 32; a++) model[a] = 32'h0;
        idle(); bus16 = 1'b0; word_addr = '0; dq_i = '0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 oe", {31'h0, dq_oe}, 32'h0);
        check("R1 data", dq_o, 32'h0);
        for (int a = 0; a < 32; a++) rd_acc(a, 1'b0, 1'b0, "R1");

        // R3 / R4: full-width writes and reads over every register.
        for (int a = 0; a < 32; a++) wr_acc(a, 4'h0, 1'b0, pat(a, 0));
        for (int a = 0; a < 32; a++) rd_acc(a, 1'b0, 1'b0, "R4");
        for (int be = 0; be < 16; be++) begin
            wr_acc(5, 4'(be), 1'b0, pat(be, 7));
            rd_acc(5, 1'b0, 1'b0, "R3");
        end

        // R6 / R7 / R8 / R9: narrow mode on normal and pass-through registers.
        foreach (model[a]) begin
            if (a == 2 || a == 13 || a == 28 || a == 29 || a == 31) begin
                for (int hi = 0; hi < 2; hi++) begin
                    for (int b01 = 0; b01 < 4; b01++) begin
                        for (int b2 = 0; b2 < 2; b2++) begin
                            wr_acc(a, {1'(hi), 1'(b2), 2'(b01)}, 1'b1, pat(a, hi*8 + b01*2 + b2));
                            rd_acc(a, 1'b0, 1'b1, is_pt(a) ? "R9" : (b2 ? "R7" : "R8"));
                            rd_acc(a, 1'b1, 1'b1, is_pt(a) ? "R9" : "R8");
                            rd_acc(a, 1'b0, 1'b0, is_pt(a) ? "R9" : "R6");
                        end
                    end
                end
            end
        end

        // R2: strobes without chip select.
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            sel_n = 1'b1; rd_n = 1'b0; wr_n = 1'b0; be_n = 4'h0;
            word_addr = 5'(k); bus16 = 1'(k); dq_i = ~pat(k, 3);
            @(negedge clk);
            check("R2 oe", {31'h0, dq_oe}, 32'h0);
            idle();
        end
        for (int a = 0; a < 32; a++) rd_acc(a, 1'b0, 1'b0, "R2");

        // R10: read right after a write, and a read and write at the same edge.
        @(negedge clk);
        sel_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1; word_addr = 5'd9; be_n = 4'h0;
        bus16 = 1'b0; dq_i = 32'h1234_5678;
        @(negedge clk);
        model_write(9, 4'h0, 1'b0, 32'h1234_5678);
        wr_n = 1'b1; rd_n = 1'b0;
        @(negedge clk);
        idle();
        check("R10 next", dq_o, 32'h1234_5678);
        @(negedge clk);
        sel_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0; word_addr = 5'd9; be_n = 4'h0;
        dq_i = 32'hCAFE_F00D;
        @(negedge clk);
        idle();
        check("R10 same edge", dq_o, 32'h1234_5678);
        model_write(9, 4'h0, 1'b0, 32'hCAFE_F00D);
        rd_acc(9, 1'b0, 1'b0, "R10");

        // R1: reset in the middle of a run clears the bank again.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 32; a++) model[a] = 32'h0;
        for (int a = 0; a < 32; a += 3) rd_acc(a, 1'b0, 1'b0, "R1");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule